// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two up-counting timer/counter channels with a shared machine-cycle time base. The time base divides the input clock by twelve. Each channel is configured by a 4-bit mode nibble. That nibble chooses what the channel counts: machine cycles, or falling edges on an external pin. It also chooses whether an external level input gates the count, and which of four count layouts is used. The layouts are 13-bit, 16-bit, 8-bit with automatic reload, and a split layout that turns channel 0 into two separate 8-bit counters.

Software loads the count bytes through a simple byte-write port. It starts each channel with a run bit and reads the high and low count bytes at any time. Each channel has an overflow flag. Hardware sets the flag on rollover, and software clears it by writing 0 to it. In the split layout, channel 0's high byte takes over channel 1's run bit and overflow flag. Channel 1 then counts freely and raises no flag.

There are three finite-state machines:

- Prescaler. It steps through twelve phases, PH_0 to PH_11, and wraps from PH_11 back to PH_0. It raises the machine-cycle strobe in PH_11.
- Edge detector, one per pin. Its states are PIN_LO, PIN_HI and PIN_FALL, and it moves only on the strobe:
  - PIN_LO goes to PIN_HI when the pin reads high.
  - PIN_HI goes to PIN_FALL when the pin reads low.
  - PIN_FALL emits one count and then returns to PIN_HI or PIN_LO, according to the pin.
- Count layout, per channel. MD_13, MD_16, MD_AR8 and MD_SPLIT are selected by the mode bits. They decide how an increment, a carry and a reload are applied.

Top module: `tmr_pair`

## Requirements
- R1: A machine-cycle strobe occurs once every 12 clocks; after reset is released, a running channel in timer mode first increments at the 12th rising edge and then once per 12 clocks.
- R2: Mode bits 00 form a 13-bit counter from low byte bits 4:0 (least significant) and the high byte; low byte bits 7:5 are left unchanged; rolling over from all-ones to zero sets the channel's flag.
- R3: Mode bits 01 form a 16-bit counter {high, low}; rollover from 0xFFFF to 0x0000 sets the channel's flag.
- R4: Mode bits 10 count in the low byte only; when the low byte overflows it is loaded from the high byte and the flag is set.
- R5: Channel 0 with mode bits 11 splits. The low byte counts 8 bits under channel 0's run, gate and select bits and sets flag 0 when it wraps. The high byte counts machine cycles whenever run1 is set, ignoring channel 0's gate and select bits, and sets flag 1 when it wraps.
- R6: Channel 1 with mode bits 11 holds its count whatever its run bit is.
- R7: While channel 0 is split, channel 1 counts in its own layout as if run1 were set, and its overflow does not set flag 1.
- R8: With mode nibble bit 2 set, a channel counts falling edges on its pin. An edge is detected when the pin is high at one machine-cycle sample and low at the next, and the count changes at the following strobe, 24 clocks after the pin falls just after a strobe. Machine cycles are not counted in this mode.
- R9: With mode nibble bit 3 set, a channel counts only while its run bit and its gate input are both high; with it clear the run bit alone enables counting.
- R10: flag_wdata bit 0 belongs to channel 0 and bit 1 to channel 1. A flag write of 0 clears that flag, a write of 1 leaves it unchanged, and a hardware set in the same clock wins.
- R11: wr_sel selects 00 channel 0 low, 01 channel 0 high, 10 channel 1 low, 11 channel 1 high. The written byte appears on the next clock, and a channel does not count in a clock in which it is written.
- R12: Reset clears all count bytes and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode0 | input | 4 | Channel 0 nibble: [3] gate enable, [2] count pin edges, [1:0] layout |
| mode1 | input | 4 | Channel 1 nibble, same fields |
| run0 | input | 1 | Channel 0 run bit |
| run1 | input | 1 | Channel 1 run bit (split high byte when channel 0 splits) |
| gate_in0 | input | 1 | Channel 0 gate level |
| gate_in1 | input | 1 | Channel 1 gate level |
| ext_in0 | input | 1 | Channel 0 count pin |
| ext_in1 | input | 1 | Channel 1 count pin |
| wr_en | input | 1 | Count byte write strobe |
| wr_sel | input | 2 | Count byte select |
| wr_data | input | 8 | Count byte write data |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data |
| cnt_lo0 | output | 8 | Channel 0 low byte |
| cnt_hi0 | output | 8 | Channel 0 high byte |
| cnt_lo1 | output | 8 | Channel 1 low byte |
| cnt_hi1 | output | 8 | Channel 1 high byte |
| ovf0 | output | 1 | Channel 0 overflow flag |
| ovf1 | output | 1 | Channel 1 overflow flag |

## Verification
The hardest case to reach from the ports is the external-edge latency, because that latency is measured against the phase of the internal machine-cycle strobe, and the strobe is not visible at the ports. The bench runs channel 1 as a free timer to act as a phase reference. It waits for channel 1's count to change, which marks a strobe edge, and then drops channel 0's pin. It then checks that the count has not changed 23 clocks later and has incremented 24 clocks later. The free-running channel 1 of the split layout has the same difficulty, so it is checked by count differences over exact 12-clock multiples.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MD_13    = 2'b00,
        MD_16    = 2'b01,
        MD_AR8   = 2'b10,
        MD_SPLIT = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        PIN_LO   = 2'b00,
        PIN_HI   = 2'b01,
        PIN_FALL = 2'b10
    } edge_st_e;

    localparam int NCH      = 2;
    localparam int BYTE_W   = 8;
    localparam int LO13_W   = 5;
    localparam int CTL_GATE = 3;
    localparam int CTL_CNT  = 2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    // phase register: PH_0 .. PH_(DIV-1), wrap to PH_0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    // strobe output in the last phase
    always_comb begin
        tick = (phase_q == LAST);
    end

    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pipe_q <= '0;
        else begin
            pipe_q[0] <= d;
            for (int s = 1; s < STAGES; s++)
                pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/tmr_edge_fsm.sv
module tmr_edge_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall_cnt
);
    edge_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                PIN_LO:   state_d = pin ? PIN_HI : PIN_LO;
                PIN_HI:   state_d = pin ? PIN_HI : PIN_FALL;
                PIN_FALL: state_d = pin ? PIN_HI : PIN_LO;
                default:  state_d = PIN_LO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PIN_LO;
        else
            state_q <= state_d;
    end

    // one count per detected fall, on the strobe after detection
    always_comb begin
        fall_cnt = tick && (state_q == PIN_FALL);
    end

    assert_fall_from_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_FALL && $past(state_q) != PIN_FALL)
            |-> ($past(state_q) == PIN_HI && !$past(pin)));

    assert_fall_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == PIN_FALL) |=> (state_q != PIN_FALL));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int BW     = 8,
    parameter int P13    = 5,
    parameter bit IS_CH0 = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_bits,
    input  logic          inc_main,
    input  logic          inc_hi,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wr_data,
    output logic [BW-1:0] lo,
    output logic [BW-1:0] hi,
    output logic          ovf_main,
    output logic          ovf_hi
);
    localparam int W13 = P13 + BW;
    localparam int W16 = 2 * BW;

    tmr_mode_e     md;
    logic [BW-1:0] lo_q, hi_q, lo_d, hi_d;
    logic [W13:0]  sum13;
    logic [W16:0]  sum16;
    logic [BW:0]   sum_lo, sum_hi;
    logic          wr_any;

    assign md     = tmr_mode_e'(mode_bits);
    assign wr_any = wr_lo | wr_hi;
    assign sum13  = {1'b0, hi_q, lo_q[P13-1:0]} + {{W13{1'b0}}, 1'b1};
    assign sum16  = {1'b0, hi_q, lo_q} + {{W16{1'b0}}, 1'b1};
    assign sum_lo = {1'b0, lo_q} + {{BW{1'b0}}, 1'b1};
    assign sum_hi = {1'b0, hi_q} + {{BW{1'b0}}, 1'b1};

    always_comb begin
        lo_d     = lo_q;
        hi_d     = hi_q;
        ovf_main = 1'b0;
        ovf_hi   = 1'b0;
        if (wr_any) begin
            if (wr_lo) lo_d = wr_data;
            if (wr_hi) hi_d = wr_data;
        end else begin
            unique case (md)
                MD_13: if (inc_main) begin
                    hi_d     = sum13[W13-1:P13];
                    lo_d     = {lo_q[BW-1:P13], sum13[P13-1:0]};
                    ovf_main = sum13[W13];
                end
                MD_16: if (inc_main) begin
                    {hi_d, lo_d} = sum16[W16-1:0];
                    ovf_main     = sum16[W16];
                end
                MD_AR8: if (inc_main) begin
                    if (sum_lo[BW]) begin
                        lo_d     = hi_q;
                        ovf_main = 1'b1;
                    end else begin
                        lo_d = sum_lo[BW-1:0];
                    end
                end
                MD_SPLIT: if (IS_CH0) begin
                    if (inc_main) begin
                        lo_d     = sum_lo[BW-1:0];
                        ovf_main = sum_lo[BW];
                    end
                    if (inc_hi) begin
                        hi_d   = sum_hi[BW-1:0];
                        ovf_hi = sum_hi[BW];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign lo = lo_q;
    assign hi = hi_q;

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (md == MD_AR8 && inc_main && !wr_any && lo_q == {BW{1'b1}})
            |=> (lo_q == $past(hi_q)));

    assert_wr_lo_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo_q == $past(wr_data)));

    assert_wr_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (hi_q == $past(wr_data)));

    if (!IS_CH0) begin : g_hold
        assert_ch1_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (md == MD_SPLIT && !wr_any) |=> $stable({hi_q, lo_q}));
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int DIV         = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode0,
    input  logic [3:0] mode1,
    input  logic       run0,
    input  logic       run1,
    input  logic       gate_in0,
    input  logic       gate_in1,
    input  logic       ext_in0,
    input  logic       ext_in1,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       flag_wr,
    input  logic [1:0] flag_wdata,
    output logic [7:0] cnt_lo0,
    output logic [7:0] cnt_hi0,
    output logic [7:0] cnt_lo1,
    output logic [7:0] cnt_hi1,
    output logic       ovf0,
    output logic       ovf1
);
    logic tick;
    logic split0;
    logic [NCH-1:0][3:0]        mode_a;
    logic [NCH-1:0]             gate_a, ext_a, run_eff;
    logic [NCH-1:0][1:0]        sync_q;
    logic [NCH-1:0]             fall, gate_ok, src, inc, inc_hi;
    logic [NCH-1:0]             ovf_main, ovf_hi, set_flag, ovf_q;
    logic [NCH-1:0][BYTE_W-1:0] lo_a, hi_a;

    assign mode_a = {mode1, mode0};
    assign gate_a = {gate_in1, gate_in0};
    assign ext_a  = {ext_in1, ext_in0};
    assign split0 = (tmr_mode_e'(mode0[1:0]) == MD_SPLIT);

    // channel 1 runs freely while channel 0 borrows its run bit
    assign run_eff[0] = run0;
    assign run_eff[1] = split0 ? 1'b1 : run1;

    tmr_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [1:0] SEL_LO = 2'(2 * i);
        localparam logic [1:0] SEL_HI = 2'(2 * i + 1);

        tmr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    ({gate_a[i], ext_a[i]}),
            .q    (sync_q[i])
        );

        tmr_edge_fsm u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .pin     (sync_q[i][0]),
            .fall_cnt(fall[i])
        );

        assign gate_ok[i] = !mode_a[i][CTL_GATE] | sync_q[i][1];
        assign src[i]     = mode_a[i][CTL_CNT] ? fall[i] : tick;
        assign inc[i]     = src[i] & run_eff[i] & gate_ok[i];
        assign inc_hi[i]  = (i == 0) ? (tick & run1) : 1'b0;

        tmr_chan #(.BW(BYTE_W), .P13(LO13_W), .IS_CH0(i == 0)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_bits(mode_a[i][1:0]),
            .inc_main (inc[i]),
            .inc_hi   (inc_hi[i]),
            .wr_lo    (wr_en && wr_sel == SEL_LO),
            .wr_hi    (wr_en && wr_sel == SEL_HI),
            .wr_data  (wr_data),
            .lo       (lo_a[i]),
            .hi       (hi_a[i]),
            .ovf_main (ovf_main[i]),
            .ovf_hi   (ovf_hi[i])
        );
    end

    assign set_flag[0] = ovf_main[0];
    assign set_flag[1] = split0 ? (ovf_hi[0] | ovf_hi[1]) : ovf_main[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovf_q <= '0;
        else
            for (int c = 0; c < NCH; c++)
                ovf_q[c] <= set_flag[c] | (ovf_q[c] & !(flag_wr & !flag_wdata[c]));
    end

    assign cnt_lo0 = lo_a[0];
    assign cnt_hi0 = hi_a[0];
    assign cnt_lo1 = lo_a[1];
    assign cnt_hi1 = hi_a[1];
    assign ovf0    = ovf_q[0];
    assign ovf1    = ovf_q[1];

    assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q[0]) |-> $past(ovf_main[0]));

    assert_flag_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_wdata[0] && ovf_q[0]) |=> ovf_q[0]);

    assert_split_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_q[1]) && $past(split0)) |-> $past(ovf_hi[0]));
endmodule

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n;
    logic [3:0] mode0, mode1;
    logic       run0, run1, gate_in0, gate_in1, ext_in0, ext_in1;
    logic       wr_en, flag_wr;
    logic [1:0] wr_sel, flag_wdata;
    logic [7:0] wr_data;
    logic [7:0] cnt_lo0, cnt_hi0, cnt_lo1, cnt_hi1;
    logic       ovf0, ovf1;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] va, vb, ex;
    int ovs;

    tmr_pair u0 (
        .clk(clk), .rst_n(rst_n), .mode0(mode0), .mode1(mode1),
        .run0(run0), .run1(run1), .gate_in0(gate_in0), .gate_in1(gate_in1),
        .ext_in0(ext_in0), .ext_in1(ext_in1), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .cnt_lo0(cnt_lo0), .cnt_hi0(cnt_hi0), .cnt_lo1(cnt_lo1), .cnt_hi1(cnt_hi1),
        .ovf0(ovf0), .ovf1(ovf1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] val(input int ch);
        return ch == 0 ? {cnt_hi0, cnt_lo0} : {cnt_hi1, cnt_lo1};
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic fl(input logic [1:0] d);
        @(negedge clk); flag_wr = 1'b1; flag_wdata = d;
        @(negedge clk); flag_wr = 1'b0;
    endtask

    task automatic runw(input logic r0, input logic r1, input int n);
        @(negedge clk); run0 = r0; run1 = r1;
        repeat (12 * n) @(negedge clk);
        run0 = 1'b0; run1 = 1'b0;
    endtask

    function automatic logic [15:0] model(input int md, input logic [15:0] v,
                                          input int n, output int ov);
        int hi = int'(v[15:8]);
        int lo = int'(v[7:0]);
        int t;
        ov = 0;
        for (int k = 0; k < n; k++) begin
            case (md)
                0: begin
                    t = hi * 32 + (lo & 31) + 1;
                    if (t == 8192) begin t = 0; ov++; end
                    hi = t >> 5;
                    lo = (lo & 224) | (t & 31);
                end
                1: begin
                    t = hi * 256 + lo + 1;
                    if (t == 65536) begin t = 0; ov++; end
                    hi = t >> 8;
                    lo = t & 255;
                end
                default: begin
                    if (lo == 255) begin lo = hi; ov++; end
                    else lo = lo + 1;
                end
            endcase
        end
        return 16'((hi << 8) | lo);
    endfunction

    task automatic sweep(input int md, input logic [15:0] st, input int n);
        for (int ch = 0; ch < 2; ch++) begin
            @(negedge clk);
            mode0 = (ch == 0) ? {2'b00, 2'(md)} : 4'b0001;
            mode1 = (ch == 1) ? {2'b00, 2'(md)} : 4'b0001;
            wr(2'(2 * ch + 1), st[15:8]);
            wr(2'(2 * ch), st[7:0]);
            fl(2'b00);
            runw(ch == 0, ch == 1, n);
            ex = model(md, st, n, ovs);
            if (md == 0) begin
                chk("R2 13-bit count", val(ch), ex);
                chk("R2 13-bit flag", ch == 0 ? ovf0 : ovf1, ovs > 0);
            end else if (md == 1) begin
                chk("R3 16-bit count", val(ch), ex);
                chk("R3 16-bit flag", ch == 0 ? ovf0 : ovf1, ovs > 0);
            end else begin
                chk("R4 reload count", val(ch), ex);
                chk("R4 reload flag", ch == 0 ? ovf0 : ovf1, ovs > 0);
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] s13 [5] = '{16'h0000, 16'h12FF, 16'hFF1E, 16'hFFFF, 16'hABE0};
        logic [15:0] s16 [5] = '{16'h0000, 16'h00FE, 16'h0FFF, 16'hFFF0, 16'hFFFE};
        logic [15:0] sar [5] = '{16'h00FD, 16'h7F7F, 16'hF0FE, 16'hFEFF, 16'h0000};
        int n13 [3] = '{1, 3, 40};
        int n16 [3] = '{1, 5, 20};
        int nar [3] = '{2, 5, 20};
        rst_n = 1'b0; mode0 = 4'b0001; mode1 = 4'b0001;
        run0 = 1'b1; run1 = 1'b0; gate_in0 = 1'b0; gate_in1 = 1'b0;
        ext_in0 = 1'b0; ext_in1 = 1'b0; wr_en = 1'b0; wr_sel = 2'b00;
        wr_data = 8'h00; flag_wr = 1'b0; flag_wdata = 2'b00;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset counts", {cnt_hi0, cnt_lo0, cnt_hi1, cnt_lo1}, 32'h0);
        chk("R12 reset flags", {ovf1, ovf0}, 2'b00);
        rst_n = 1'b1;
        // R1 first strobe on the 12th edge
        repeat (11) @(negedge clk);
        chk("R1 before first strobe", val(0), 16'h0000);
        @(negedge clk);
        chk("R1 at first strobe", val(0), 16'h0001);
        run0 = 1'b0;
        runw(1'b1, 1'b0, 30);
        chk("R1 one count per 12 clocks", val(0), 16'd31);

        // R11 byte writes
        wr(2'b01, 8'hA5);
        chk("R11 write ch0 high", cnt_hi0, 8'hA5);
        wr(2'b10, 8'h3C);
        chk("R11 write ch1 low", cnt_lo1, 8'h3C);

        foreach (s16[i]) foreach (n16[j]) sweep(1, s16[i], n16[j]);
        foreach (s13[i]) foreach (n13[j]) sweep(0, s13[i], n13[j]);
        foreach (sar[i]) foreach (nar[j]) sweep(2, sar[i], nar[j]);

        // R9 gating
        mode0 = 4'b1001; mode1 = 4'b0001;
        wr(2'b01, 8'h00); wr(2'b00, 8'h00);
        gate_in0 = 1'b0; repeat (4) @(negedge clk);
        runw(1'b1, 1'b0, 10);
        chk("R9 gate low blocks", val(0), 16'h0000);
        gate_in0 = 1'b1; repeat (4) @(negedge clk);
        runw(1'b1, 1'b0, 10);
        chk("R9 gate high counts", val(0), 16'd10);
        mode0 = 4'b0001; gate_in0 = 1'b0; repeat (4) @(negedge clk);
        runw(1'b1, 1'b0, 5);
        chk("R9 gate ignored when clear", val(0), 16'd15);

        // R8 external edges, phase from channel 1 timer
        mode0 = 4'b0101; mode1 = 4'b0001;
        wr(2'b01, 8'h00); wr(2'b00, 8'h00);
        ext_in0 = 1'b1; run0 = 1'b1; run1 = 1'b1;
        repeat (30) @(negedge clk);
        chk("R8 no machine-cycle counts", val(0), 16'h0000);
        va = val(1);
        do @(negedge clk); while (val(1) == va);
        ext_in0 = 1'b0;
        repeat (23) @(negedge clk);
        chk("R8 before latency", val(0), 16'h0000);
        @(negedge clk);
        chk("R8 increment after latency", val(0), 16'h0001);
        for (int k = 0; k < 10; k++) begin
            ext_in0 = 1'b1; repeat (12) @(negedge clk);
            ext_in0 = 1'b0; repeat (12) @(negedge clk);
        end
        repeat (36) @(negedge clk);
        chk("R8 pulses at clk/24", val(0), 16'd11);
        repeat (120) @(negedge clk);
        chk("R8 static pin no count", val(0), 16'd11);
        run0 = 1'b0; run1 = 1'b0;

        // R5 split mode
        mode0 = 4'b0011; mode1 = 4'b0001;
        wr(2'b00, 8'd10); wr(2'b01, 8'd20);
        runw(1'b1, 1'b0, 7);
        chk("R5 split low under run0", val(0), {8'd20, 8'd17});
        runw(1'b0, 1'b1, 5);
        chk("R5 split high under run1", val(0), {8'd25, 8'd17});
        mode0 = 4'b0111; ext_in0 = 1'b1; repeat (30) @(negedge clk);
        runw(1'b1, 1'b1, 6);
        chk("R5 high ignores select", val(0), {8'd31, 8'd17});
        mode0 = 4'b0011;
        wr(2'b01, 8'hFE); fl(2'b00);
        runw(1'b0, 1'b1, 2);
        chk("R5 high wrap", cnt_hi0, 8'h00);
        chk("R5 high sets flag1", {ovf1, ovf0}, 2'b10);
        wr(2'b00, 8'hFF); fl(2'b00);
        runw(1'b1, 1'b0, 1);
        chk("R5 low wrap", cnt_lo0, 8'h00);
        chk("R5 low sets flag0", {ovf1, ovf0}, 2'b01);

        // R7 channel 1 free while split
        wr(2'b11, 8'hFF); wr(2'b10, 8'hF0); fl(2'b00);
        va = val(1);
        repeat (120) @(negedge clk);
        vb = val(1);
        chk("R7 free count", 16'(vb - va), 16'd10);
        repeat (12 * 40) @(negedge clk);
        chk("R7 wrapped", val(1) < 16'h0040, 1'b1);
        chk("R7 no flag1", ovf1, 1'b0);

        // R6 channel 1 stopped
        mode0 = 4'b0001; mode1 = 4'b0011;
        wr(2'b11, 8'h12); wr(2'b10, 8'h34); fl(2'b00);
        runw(1'b0, 1'b1, 5);
        chk("R6 ch1 holds", val(1), 16'h1234);
        chk("R6 no flag", ovf1, 1'b0);

        // R10 flag writes
        mode1 = 4'b0001;
        wr(2'b01, 8'hFF); wr(2'b00, 8'hFF);
        wr(2'b11, 8'hFF); wr(2'b10, 8'hFF); fl(2'b00);
        runw(1'b1, 1'b1, 1);
        chk("R10 both set", {ovf1, ovf0}, 2'b11);
        fl(2'b11);
        chk("R10 write one keeps", {ovf1, ovf0}, 2'b11);
        fl(2'b01);
        chk("R10 clear flag1 only", {ovf1, ovf0}, 2'b01);
        fl(2'b00);
        chk("R10 clear flag0", {ovf1, ovf0}, 2'b00);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule